// File: doc/BRIEF.md
# ACPI sleep state sequencer

This block walks a system between the working state S0 and the sleep states S1, S3, S4 and S5. Software picks a target by placing a 3-bit code on the type input and pulsing the enable write strobe. A valid request first parks the processor in the C2 stop-clock state through a request/acknowledge handshake. Only after the acknowledge does the block drive the active-low sleep-control lines. Processor throttling is granted only while the system is awake and no sleep request is being accepted, so a sleep request always wins over throttling.

A power button held low past a programmable number of always-on clock cycles forces soft-off (S5) at once. This path waits for no processor acknowledge and needs no other clock. The whole sequencer runs on the always-on real-time clock. A wake event releases the sleep lines one at a time, in the reverse of their weight (S5 line, then S3 line, then the S1/processor-sleep line), spaced by a programmable gap, and the block then returns to S0. A flag records whether the most recent sleep entry came from the button override.

The MOBILE parameter picks the board variant. The desktop build drives a processor-sleep line for S1. The mobile build instead drives a clock-generator S1 line, and it also holds that line in every deeper state.

Top module: `slp_sequencer`

## Requirements
- R1: In S0, a write strobe with type code 1, 3, 4 or 5 (the code equals the S-state number) latches that target. On the next edge, slp_en_o and c2_req_o go high. A write strobe seen while a request is pending, or while asleep, has no effect on the target.
- R2: Type codes 0, 2, 6 and 7 are reserved. A write with a reserved code causes no transition, and slp_en_o stays low.
- R3: thr_en_o is high only in S0, only when the software or thermal throttle request is high, and only when no valid sleep write is being accepted in the same cycle. It is never high together with c2_req_o or with any asserted sleep line.
- R4: Sleep lines assert on the edge that samples c2_ack_i high while c2_req_o is high. slp_en_o and c2_req_o drop on that same edge. No sleep line asserts while c2_req_o is waiting.
- R5: Desktop build (MOBILE=0), sleep lines {cpuslp_no, slp_s1_no, slp_s3_no, slp_s5_no} active low: S1 gives 0111, S3 gives 1101, S4 and S5 give 1100.
- R6: Mobile build (MOBILE=1), same bit order: S1 gives 1011, S3 gives 1001, S4 and S5 give 1000. cpuslp_no stays high.
- R7: With pwrbtn_ni sampled low on OVR_CYCLES+1 consecutive edges, the block enters S5 on the last of those edges from any state, with no C2 handshake, and drops c2_req_o and slp_en_o. A press of OVR_CYCLES edges or fewer has no effect, and a continued hold does not trigger again.
- R8: ovr_flag_o goes high on an override entry. It stays high through the wake, and a later software sleep entry clears it.
- R9: wake_i sampled high while asleep releases the sleep lines. The highest asserted line goes first, one edge after wake_i is sampled. Each further line goes wake_gap_i+1 edges after the one before, in the order S5 line, S3 line, S1/processor-sleep line, and lines not asserted are skipped. wake_i outside a sleep state is ignored.
- R10: cur_s_o shows the target S-number while asleep or waking. It returns to 0 on the edge that releases the last line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rtc_clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slp_typ_i | input | 3 | Requested sleep type code |
| slp_en_wr_i | input | 1 | Write strobe of the sleep enable bit |
| slp_en_o | output | 1 | Sleep request pending |
| pwrbtn_ni | input | 1 | Power button, low when pressed |
| sw_thr_req_i | input | 1 | Software throttle request |
| thrm_thr_req_i | input | 1 | Thermal throttle request |
| thr_en_o | output | 1 | Throttling granted |
| c2_req_o | output | 1 | Stop-clock (C2) request to the processor |
| c2_ack_i | input | 1 | Stop-clock acknowledge |
| wake_i | input | 1 | Wake event |
| wake_gap_i | input | GAP_W | Cycles between line releases on wake, minus one |
| cpuslp_no | output | 1 | Processor sleep, active low |
| slp_s1_no | output | 1 | S1 line to the clock generator, active low |
| slp_s3_no | output | 1 | S3 line, active low |
| slp_s5_no | output | 1 | S5 line, active low |
| cur_s_o | output | 3 | Current S-state number |
| ovr_flag_o | output | 1 | Last sleep entry was a button override |

## Verification
The bench builds two copies side by side, one with MOBILE=0 and one with MOBILE=1, both with OVR_CYCLES=8 and GAP_W=4, and runs them with a wake gap of 2. The short override threshold lets the bench probe the boundary between an 8-edge and a 9-edge press, including a press made while a C2 request waits for an acknowledge that never arrives. The short gap lets it check every release edge of the three-line mobile wake and the two-line desktop wake exactly.

// File: rtl/slp_seq_pkg.sv
package slp_seq_pkg;

  typedef enum logic [1:0] {
    ST_ON   = 2'd0,
    ST_C2   = 2'd1,
    ST_SLP  = 2'd2,
    ST_WAKE = 2'd3
  } seq_st_e;

  // type code equals the S-state number
  localparam logic [2:0] TYP_S1 = 3'd1;
  localparam logic [2:0] TYP_S3 = 3'd3;
  localparam logic [2:0] TYP_S4 = 3'd4;
  localparam logic [2:0] TYP_S5 = 3'd5;

  typedef struct packed {
    logic s5;
    logic s3;
    logic s1;  // S1 line (mobile) or processor sleep (desktop)
  } rails_t;

  function automatic logic typ_ok(input logic [2:0] t);
    return (t == TYP_S1) || (t == TYP_S3) || (t == TYP_S4) || (t == TYP_S5);
  endfunction

  function automatic rails_t rails_for(input logic [2:0] t, input logic mob);
    rails_t r;
    r.s5 = (t == TYP_S4) || (t == TYP_S5);
    r.s3 = r.s5 || (t == TYP_S3);
    r.s1 = (t == TYP_S1) || (mob && r.s3);
    return r;
  endfunction

endpackage

// File: rtl/slp_ovr_det.sv
module slp_ovr_det #(
  parameter int unsigned OVR_CYCLES = 131072
) (
  input  logic rtc_clk_i,
  input  logic rst_ni,
  input  logic pwrbtn_ni,
  output logic ovr_o
);
  localparam int unsigned CNT_W = $clog2(OVR_CYCLES + 2);
  localparam logic [CNT_W-1:0] HIT = CNT_W'(OVR_CYCLES);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(OVR_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge rtc_clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (pwrbtn_ni)  cnt_q <= '0;
    else if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
  end

  // fires on the (OVR_CYCLES+1)th low sample, once per press
  assign ovr_o = !pwrbtn_ni && (cnt_q == HIT);

  AST_OVR_ONE_SHOT: assert property (@(posedge rtc_clk_i) disable iff (!rst_ni)
    ovr_o |=> !ovr_o); // R7

endmodule

// File: rtl/slp_rail_seq.sv
module slp_rail_seq
  import slp_seq_pkg::*;
#(
  parameter int unsigned GAP_W = 8
) (
  input  logic             rtc_clk_i,
  input  logic             rst_ni,
  input  logic             enter_i,
  input  rails_t           enter_rails_i,
  input  logic             wake_start_i,
  input  logic [GAP_W-1:0] gap_i,
  output rails_t           rails_o,
  output logic             done_o
);
  rails_t           rails_q, rails_clr;
  logic             run_q, step;
  logic [GAP_W-1:0] cnt_q;

  // drop the heaviest line still held
  always_comb begin
    rails_clr = rails_q;
    if (rails_q.s5)      rails_clr.s5 = 1'b0;
    else if (rails_q.s3) rails_clr.s3 = 1'b0;
    else                 rails_clr.s1 = 1'b0;
  end

  assign step   = run_q && (cnt_q == '0);
  assign done_o = step && (rails_clr == '0);

  always_ff @(posedge rtc_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rails_q <= '0;
      run_q   <= 1'b0;
      cnt_q   <= '0;
    end else if (enter_i) begin
      rails_q <= enter_rails_i;
      run_q   <= 1'b0;
      cnt_q   <= '0;
    end else if (wake_start_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q) begin
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        rails_q <= rails_clr;
        if (done_o) run_q <= 1'b0;
        else        cnt_q <= gap_i;
      end
    end
  end

  assign rails_o = rails_q;

  AST_S3_AFTER_S5: assert property (@(posedge rtc_clk_i) disable iff (!rst_ni)
    $fell(rails_q.s3) |-> !rails_q.s5); // R9
  AST_S1_LAST: assert property (@(posedge rtc_clk_i) disable iff (!rst_ni)
    $fell(rails_q.s1) |-> (!rails_q.s3 && !rails_q.s5)); // R9

endmodule

// File: rtl/slp_ctrl_fsm.sv
module slp_ctrl_fsm
  import slp_seq_pkg::*;
(
  input  logic       rtc_clk_i,
  input  logic       rst_ni,
  input  logic [2:0] typ_i,
  input  logic       slp_en_wr_i,
  input  logic       ovr_i,
  input  logic       c2_ack_i,
  input  logic       wake_i,
  input  logic       rails_done_i,
  output seq_st_e    st_o,
  output logic [2:0] tgt_o,
  output logic       slp_en_o,
  output logic       c2_req_o,
  output logic       ovr_flag_o,
  output logic       sw_req_o,
  output logic       enter_o,
  output logic [2:0] enter_typ_o,
  output logic       wake_start_o
);
  seq_st_e    st_q;
  logic [2:0] tgt_q;
  logic       slp_en_q, ovr_flag_q;

  assign sw_req_o = (st_q == ST_ON) && slp_en_wr_i && typ_ok(typ_i);

  always_ff @(posedge rtc_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_ON;
      tgt_q      <= '0;
      slp_en_q   <= 1'b0;
      ovr_flag_q <= 1'b0;
    end else if (ovr_i) begin
      st_q       <= ST_SLP;
      tgt_q      <= TYP_S5;
      slp_en_q   <= 1'b0;
      ovr_flag_q <= 1'b1;
    end else begin
      unique case (st_q)
        ST_ON: if (sw_req_o) begin
          st_q     <= ST_C2;
          tgt_q    <= typ_i;
          slp_en_q <= 1'b1;
        end
        ST_C2: if (c2_ack_i) begin
          st_q       <= ST_SLP;
          slp_en_q   <= 1'b0;
          ovr_flag_q <= 1'b0;
        end
        ST_SLP:  if (wake_i) st_q <= ST_WAKE;
        ST_WAKE: if (rails_done_i) st_q <= ST_ON;
        default: st_q <= ST_ON;
      endcase
    end
  end

  assign c2_req_o     = (st_q == ST_C2);
  assign enter_o      = ovr_i || (c2_req_o && c2_ack_i);
  assign enter_typ_o  = ovr_i ? TYP_S5 : tgt_q;
  assign wake_start_o = (st_q == ST_SLP) && wake_i && !ovr_i;
  assign st_o         = st_q;
  assign tgt_o        = tgt_q;
  assign slp_en_o     = slp_en_q;
  assign ovr_flag_o   = ovr_flag_q;

  AST_RSVD_NO_MOVE: assert property (@(posedge rtc_clk_i) disable iff (!rst_ni)
    (st_q == ST_ON && slp_en_wr_i && !typ_ok(typ_i) && !ovr_i)
      |=> (st_q == ST_ON && !slp_en_q)); // R2
  AST_C2_FIRST: assert property (@(posedge rtc_clk_i) disable iff (!rst_ni)
    (st_q == ST_SLP && $past(st_q) != ST_SLP && !ovr_flag_q)
      |-> ($past(st_q) == ST_C2)); // R4
  AST_OVR_S5: assert property (@(posedge rtc_clk_i) disable iff (!rst_ni)
    ovr_i |=> (st_q == ST_SLP && tgt_q == TYP_S5 && ovr_flag_q && !slp_en_q)); // R7

endmodule

// File: rtl/slp_sequencer.sv
module slp_sequencer
  import slp_seq_pkg::*;
#(
  parameter bit          MOBILE     = 1'b0,
  parameter int unsigned OVR_CYCLES = 131072,
  parameter int unsigned GAP_W      = 8
) (
  input  logic             rtc_clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       slp_typ_i,
  input  logic             slp_en_wr_i,
  output logic             slp_en_o,
  input  logic             pwrbtn_ni,
  input  logic             sw_thr_req_i,
  input  logic             thrm_thr_req_i,
  output logic             thr_en_o,
  output logic             c2_req_o,
  input  logic             c2_ack_i,
  input  logic             wake_i,
  input  logic [GAP_W-1:0] wake_gap_i,
  output logic             cpuslp_no,
  output logic             slp_s1_no,
  output logic             slp_s3_no,
  output logic             slp_s5_no,
  output logic [2:0]       cur_s_o,
  output logic             ovr_flag_o
);
  seq_st_e    st;
  logic [2:0] tgt, enter_typ;
  logic       ovr, sw_req, enter, wake_start, rails_done;
  rails_t     rails;

  slp_ovr_det #(.OVR_CYCLES(OVR_CYCLES)) i_ovr_det (
    .rtc_clk_i (rtc_clk_i),
    .rst_ni    (rst_ni),
    .pwrbtn_ni (pwrbtn_ni),
    .ovr_o     (ovr)
  );

  slp_ctrl_fsm i_ctrl_fsm (
    .rtc_clk_i    (rtc_clk_i),
    .rst_ni       (rst_ni),
    .typ_i        (slp_typ_i),
    .slp_en_wr_i  (slp_en_wr_i),
    .ovr_i        (ovr),
    .c2_ack_i     (c2_ack_i),
    .wake_i       (wake_i),
    .rails_done_i (rails_done),
    .st_o         (st),
    .tgt_o        (tgt),
    .slp_en_o     (slp_en_o),
    .c2_req_o     (c2_req_o),
    .ovr_flag_o   (ovr_flag_o),
    .sw_req_o     (sw_req),
    .enter_o      (enter),
    .enter_typ_o  (enter_typ),
    .wake_start_o (wake_start)
  );

  slp_rail_seq #(.GAP_W(GAP_W)) i_rail_seq (
    .rtc_clk_i     (rtc_clk_i),
    .rst_ni        (rst_ni),
    .enter_i       (enter),
    .enter_rails_i (rails_for(enter_typ, MOBILE)),
    .wake_start_i  (wake_start),
    .gap_i         (wake_gap_i),
    .rails_o       (rails),
    .done_o        (rails_done)
  );

  // sleep request outranks throttling in the cycle it is accepted
  assign thr_en_o = (st == ST_ON) && !sw_req && !ovr && (sw_thr_req_i || thrm_thr_req_i);
  assign cur_s_o  = (st == ST_SLP || st == ST_WAKE) ? tgt : 3'd0;

  assign slp_s3_no = !rails.s3;
  assign slp_s5_no = !rails.s5;

  generate
    if (MOBILE) begin : g_mobile
      assign slp_s1_no = !rails.s1;
      assign cpuslp_no = 1'b1;
    end else begin : g_desktop
      assign slp_s1_no = 1'b1;
      assign cpuslp_no = !rails.s1;
    end
  endgenerate

  AST_THR_EXCL: assert property (@(posedge rtc_clk_i) disable iff (!rst_ni)
    thr_en_o |-> (!c2_req_o && cpuslp_no && slp_s1_no && slp_s3_no && slp_s5_no)); // R3

endmodule

// File: tb/test_slp_sequencer.sv
module test_slp_sequencer;
  localparam int unsigned GAP_W = 4;
  localparam int unsigned OVR   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] typ = '0;
  logic wr = 0, pwrbtn_n = 1, sw_thr = 0, thrm_thr = 0, ack = 0, wake = 0;
  logic [GAP_W-1:0] gap = 4'd2;

  logic slp_en_d, thr_d, c2_d, cpu_d, s1_d, s3_d, s5_d, ovf_d;
  logic slp_en_m, thr_m, c2_m, cpu_m, s1_m, s3_m, s5_m, ovf_m;
  logic [2:0] cs_d, cs_m;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  slp_sequencer #(.MOBILE(1'b0), .OVR_CYCLES(OVR), .GAP_W(GAP_W)) i_slp_sequencer (
    .rtc_clk_i(clk), .rst_ni(rst_n), .slp_typ_i(typ), .slp_en_wr_i(wr), .slp_en_o(slp_en_d),
    .pwrbtn_ni(pwrbtn_n), .sw_thr_req_i(sw_thr), .thrm_thr_req_i(thrm_thr), .thr_en_o(thr_d),
    .c2_req_o(c2_d), .c2_ack_i(ack), .wake_i(wake), .wake_gap_i(gap), .cpuslp_no(cpu_d),
    .slp_s1_no(s1_d), .slp_s3_no(s3_d), .slp_s5_no(s5_d), .cur_s_o(cs_d), .ovr_flag_o(ovf_d));

  slp_sequencer #(.MOBILE(1'b1), .OVR_CYCLES(OVR), .GAP_W(GAP_W)) i_slp_sequencer_m (
    .rtc_clk_i(clk), .rst_ni(rst_n), .slp_typ_i(typ), .slp_en_wr_i(wr), .slp_en_o(slp_en_m),
    .pwrbtn_ni(pwrbtn_n), .sw_thr_req_i(sw_thr), .thrm_thr_req_i(thrm_thr), .thr_en_o(thr_m),
    .c2_req_o(c2_m), .c2_ack_i(ack), .wake_i(wake), .wake_gap_i(gap), .cpuslp_no(cpu_m),
    .slp_s1_no(s1_m), .slp_s3_no(s3_m), .slp_s5_no(s5_m), .cur_s_o(cs_m), .ovr_flag_o(ovf_m));

  // {typ, desktop {cpu,s1,s3,s5}, mobile {cpu,s1,s3,s5}}; all-ones = reserved
  localparam logic [10:0] VEC [8] = '{
    {3'd0, 4'b1111, 4'b1111},
    {3'd1, 4'b0111, 4'b1011},
    {3'd2, 4'b1111, 4'b1111},
    {3'd3, 4'b1101, 4'b1001},
    {3'd4, 4'b1100, 4'b1000},
    {3'd5, 4'b1100, 4'b1000},
    {3'd6, 4'b1111, 4'b1111},
    {3'd7, 4'b1111, 4'b1111}
  };

  function automatic logic [3:0] od();
    return {cpu_d, s1_d, s3_d, s5_d};
  endfunction
  function automatic logic [3:0] om();
    return {cpu_m, s1_m, s3_m, s5_m};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic sw_write(input logic [2:0] t);
    @(negedge clk); typ = t; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask
  task automatic ack_c2();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask
  task automatic pulse_wake();
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset lines desktop", od(), 4'hF);
    chk("reset lines mobile", om(), 4'hF);
    chk("reset c2_req", c2_d, 0);
    chk("R10 reset cur_s", cs_d, 0);
    chk("R8 reset ovr_flag", ovf_d, 0);
    chk("R3 reset thr_en", thr_d, 0);
    chk("R1 reset slp_en", slp_en_d, 0);

    for (int i = 0; i < 8; i++) begin
      logic [2:0] t;
      logic [3:0] ed, em;
      logic vld;
      t = VEC[i][10:8]; ed = VEC[i][7:4]; em = VEC[i][3:0];
      vld = (ed != 4'hF);
      sw_write(t);
      chk(vld ? "R1 c2_req on valid write" : "R2 reserved no c2_req", c2_d, vld);
      chk(vld ? "R1 slp_en on valid write" : "R2 reserved slp_en low", slp_en_d, vld);
      chk("R4 lines idle before ack", od(), 4'hF);
      chk("R4 lines idle before ack mobile", om(), 4'hF);
      if (vld) begin
        ack_c2();
        chk("R5 desktop lines", od(), ed);
        chk("R6 mobile lines", om(), em);
        chk("R10 cur_s asleep", cs_d, t);
        chk("R4 slp_en cleared", slp_en_d, 0);
        chk("R4 c2_req cleared", c2_d, 0);
        pulse_wake();
        repeat (12) @(negedge clk);
        chk("R9 desktop released", od(), 4'hF);
        chk("R9 mobile released", om(), 4'hF);
        chk("R10 cur_s back to 0", cs_m, 0);
      end else begin
        chk("R2 reserved cur_s", cs_d, 0);
      end
    end

    // R9 release timing, gap 2: steps at k+1, k+4, k+7
    sw_write(3'd5);
    ack_c2();
    pulse_wake();
    @(negedge clk);
    chk("R9 k+1 mobile s5 off s3 on", om(), 4'b1001);
    chk("R9 k+1 desktop", od(), 4'b1101);
    @(negedge clk); @(negedge clk);
    chk("R9 k+3 s3 still held", om(), 4'b1001);
    @(negedge clk);
    chk("R9 k+4 mobile s3 off", om(), 4'b1011);
    chk("R9 k+4 desktop done", od(), 4'hF);
    chk("R10 k+4 desktop cur_s", cs_d, 0);
    chk("R10 k+4 mobile still waking", cs_m, 5);
    @(negedge clk); @(negedge clk);
    chk("R9 k+6 s1 still held", om(), 4'b1011);
    @(negedge clk);
    chk("R9 k+7 mobile done", om(), 4'hF);
    chk("R10 k+7 mobile cur_s", cs_m, 0);

    // R3 throttle arbitration
    @(negedge clk); sw_thr = 1'b1; #1;
    chk("R3 thr granted in S0", thr_d, 1);
    @(negedge clk); typ = 3'd3; wr = 1'b1; #1;
    chk("R3 sleep write beats thr", thr_d, 0);
    @(negedge clk); wr = 1'b0; thrm_thr = 1'b1; #1;
    chk("R3 thermal blocked in C2", thr_d, 0);
    chk("R1 c2_req pending", c2_d, 1);
    sw_write(3'd5);
    chk("R1 second write ignored slp_en", slp_en_d, 1);
    ack_c2();
    chk("R1 target kept S3", od(), 4'b1101);
    chk("R1 cur_s kept 3", cs_d, 3);
    chk("R3 thr off asleep", thr_d, 0);
    sw_thr = 1'b0; thrm_thr = 1'b0;
    pulse_wake();
    repeat (12) @(negedge clk);
    chk("R9 released after thr test", od(), 4'hF);

    // R7 press of exactly OVR edges
    @(negedge clk); pwrbtn_n = 1'b0;
    repeat (OVR) @(negedge clk);
    chk("R7 short press no entry", od(), 4'hF);
    pwrbtn_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 short press cur_s", cs_d, 0);

    // R7 override while C2 never acknowledged
    sw_write(3'd1);
    pwrbtn_n = 1'b0;
    repeat (OVR) @(negedge clk);
    chk("R7 waiting in C2", c2_d, 1);
    chk("R4 no line while waiting", od(), 4'hF);
    @(negedge clk);
    chk("R7 override desktop S5", od(), 4'b1100);
    chk("R7 override mobile S5", om(), 4'b1000);
    chk("R7 override cur_s", cs_d, 5);
    chk("R7 c2_req dropped", c2_d, 0);
    chk("R7 slp_en dropped", slp_en_d, 0);
    chk("R8 flag set", ovf_d, 1);
    repeat (4) @(negedge clk);
    pulse_wake();
    repeat (12) @(negedge clk);
    chk("R7 no retrigger while held", cs_m, 0);
    chk("R7 lines released while held", om(), 4'hF);
    pwrbtn_n = 1'b1;
    @(negedge clk);
    chk("R8 flag held after wake", ovf_m, 1);
    sw_write(3'd1);
    ack_c2();
    chk("R8 flag cleared by sw sleep", ovf_d, 0);
    chk("R5 desktop S1 again", od(), 4'b0111);
    pulse_wake();
    repeat (12) @(negedge clk);

    // R9 wake ignored in S0
    pulse_wake();
    repeat (4) @(negedge clk);
    chk("R9 wake in S0 ignored", cs_d, 0);
    chk("R9 wake in S0 lines", od(), 4'hF);
    chk("R9 wake in S0 c2_req", c2_d, 0);

    summary();
  end
endmodule